// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Empty Interrupt

This block sends bytes on an asynchronous serial line. The CPU writes a byte into a holding register. The hardware moves that byte into a shift register as soon as the shifter is free, so the CPU can load the next byte while the current frame is still going out. A holding-empty flag is set each time the holding register hands its byte to the shifter. That flag, gated by an interrupt enable, drives a level interrupt request. The handler refills the holding register, and frames then follow each other with no idle gap.

There are two frame formats. The plain format is a low start bit, eight data bits sent least significant bit first, and a high stop bit. The tagged format adds one address/data marker bit between the last data bit and the stop bit. An external baud tick paces the shifting: every bit lasts a fixed number of ticks. Receive logic and baud generation are outside the block.

Top module: `uart_tx_buf`

## Requirements
- R1: After reset `txd` is 1, `overrun` is 0, and the holding register is empty, so `irq` is 0 while `irq_en` is 0.
- R2: `irq` is 1 exactly while the holding register is empty and `irq_en` is 1. Setting `irq_en` after reset raises `irq` at once.
- R3: A write (`wr_en` high at a clock edge) clears the empty flag. Software has no other way to clear it, so `irq` is 0 in the cycle after the write.
- R4: When the shifter is idle, a buffered byte moves into it at the next clock edge. The empty flag sets at that same edge and the start bit (`txd` = 0) begins.
- R5: With `mp_mode` = 0, a frame is start (0), data bits 0 to 7 with the LSB first, then stop (1). Each bit lasts TPB = 16 baud ticks.
- R6: With `mp_mode` = 1, a frame is start, data bits 0 to 7, a marker bit, then stop. The marker value is `mark_bit` sampled at the edge where the byte enters the shifter, not when it was written.
- R7: A byte that is waiting when a stop bit ends moves to the shifter at that edge. Its start bit follows with no gap, so consecutive start bits are 10×16 (plain) or 11×16 (tagged) ticks apart.
- R8: A write while the holding register is full (and not being emptied in that cycle) replaces the buffered byte, and the older byte is never sent. It also sets `overrun`, which stays 1 until reset.
- R9: A write on the same edge that moves the held byte into the shifter is not an overrun. The new byte is held, the empty flag stays 0, and both bytes are sent in order.
- R10: `txd` is 1 whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Byte to transmit |
| mp_mode | input | 1 | 0: plain frame, 1: frame with marker bit |
| mark_bit | input | 1 | Marker value, sampled when a byte enters the shifter |
| irq_en | input | 1 | Transmit interrupt enable |
| baud_tick | input | 1 | One pulse per baud sub-tick |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Level interrupt request (empty and enabled) |
| overrun | output | 1 | Sticky flag: a buffered byte was overwritten |

## Verification
A CPU write and the hand-over of the held byte to the shifter can land on the same clock edge. In that edge the empty flag is pulled both ways, and the overrun rule has to tell a real overwrite from a refill. The bench provokes this by writing two bytes on consecutive edges into an idle transmitter. It then checks that `irq` stays low, that `overrun` stays 0, and that the scoreboard receives both frames back to back. A separate triple write into a full buffer provides the real overrun case for contrast.

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DW  = 8,
  parameter int TPB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          mp_mode,
  input  logic          mark_bit,
  input  logic          irq_en,
  input  logic          baud_tick,
  output logic          txd,
  output logic          irq,
  output logic          overrun
);
  localparam int FW = DW + 3;
  localparam int TW = (TPB > 1) ? $clog2(TPB) : 1;
  localparam int CW = $clog2(FW + 1);

  logic [DW-1:0] hold;
  logic          empty, busy, ovr;
  logic [FW-1:0] sh;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] bcnt, last;

  wire bit_end   = busy & baud_tick & (tcnt == TW'(TPB - 1));
  wire frame_end = bit_end & (bcnt == last);
  wire load      = ~empty & (~busy | frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      empty <= 1'b1;
      ovr   <= 1'b0;
    end else if (wr_en) begin
      hold  <= wr_data;
      empty <= 1'b0;
      if (!empty && !load) ovr <= 1'b1;
    end else if (load) begin
      empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      tcnt <= '0;
      bcnt <= '0;
      last <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sh   <= {1'b1, (mp_mode ? mark_bit : 1'b1), hold, 1'b0};
      last <= mp_mode ? CW'(FW - 1) : CW'(FW - 2);
      tcnt <= '0;
      bcnt <= '0;
    end else if (frame_end) begin
      busy <= 1'b0;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        tcnt <= '0;
        bcnt <= bcnt + 1'b1;
        sh   <= {1'b1, sh[FW-1:1]};
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd     = busy ? sh[0] : 1'b1;
  assign irq     = empty & irq_en;
  assign overrun = ovr;
endmodule

module uart_tx_buf_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic irq_en,
  input logic irq,
  input logic txd,
  input logic overrun,
  input logic busy,
  input logic empty
);
  // R2
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R3
  wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);
  // R4
  idle_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !empty && !wr_en) |=> (empty && busy && !txd));
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
endmodule

bind uart_tx_buf uart_tx_buf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_en(irq_en), .irq(irq),
  .txd(txd), .overrun(overrun), .busy(busy), .empty(empty)
);

// File: tb/uart_tx_buf_tb.sv
module uart_tx_buf_tb;
  typedef struct packed {
    logic [7:0] d;
    logic       mp;
    logic       mk;
    logic       b2b;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mp_mode = 1'b0, mark_bit = 1'b0;
  logic irq_en = 1'b0, baud_tick = 1'b1;
  logic [7:0] wr_data = '0;
  logic txd, irq, overrun;
  int n_chk = 0, n_fail = 0, cyc = 0;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_buf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mp_mode(mp_mode), .mark_bit(mark_bit), .irq_en(irq_en),
    .baud_tick(baud_tick), .txd(txd), .irq(irq), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic b2b, input logic mk);
    item_t it;
    it.d = d; it.mp = mp_mode; it.mk = mk; it.b2b = b2b;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (40) @(negedge clk);
    chk("R10 idle line", txd, 1);
  endtask

  // monitor: decode frames on txd and compare with the scoreboard queue
  initial begin
    int last_start = -1;
    forever begin
      item_t it;
      int nb, st;
      logic [10:0] got, exp;
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        st = cyc;
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R5: unexpected frame, actual start expected idle");
          repeat (160) @(negedge clk);
        end else begin
          it = q[0];
          nb = it.mp ? 11 : 10;
          got = '1;
          repeat (8) @(negedge clk);
          got[0] = txd;
          for (int i = 1; i < nb; i++) begin
            repeat (16) @(negedge clk);
            got[i] = txd;
          end
          exp = it.mp ? {1'b1, it.mk, it.d, 1'b0} : {2'b11, it.d, 1'b0};
          chk(it.mp ? "R6 tagged frame" : "R5 plain frame", 32'(got), 32'(exp));
          if (it.b2b) chk("R7 gap", st - last_start, (it.mp ? 11 : 10) * 16);
          last_start = st;
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq, 0);
    chk("R1 overrun", overrun, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R2 irq on enable", irq, 1);

    // R4, R3 idle write, then R7 buffered byte
    push(8'hA5, 0, 1'b1);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = 8'hA5;
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk);
    chk("R3 irq after write", irq, 0);
    @(negedge clk);
    chk("R4 empty sets on transfer", irq, 1);
    chk("R4 start bit", txd, 0);
    push(8'h3C, 1, 1'b1);
    wr(8'h3C);
    @(negedge clk);
    chk("R3 irq cleared while busy", irq, 0);
    drain();

    // R9 write on the transfer edge
    push(8'h01, 0, 1'b1);
    push(8'hFF, 1, 1'b1);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = 8'h01;
    @(posedge clk); #1; wr_data = 8'hFF;
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk);
    chk("R9 no overrun", overrun, 0);
    chk("R9 empty stays clear", irq, 0);
    drain();
    chk("R9 overrun after drain", overrun, 0);

    // R6 tagged frames, marker sampled at transfer
    mp_mode = 1'b1; mark_bit = 1'b1;
    push(8'h5A, 0, 1'b1);
    wr(8'h5A);
    push(8'h81, 1, 1'b0);
    wr(8'h81);
    repeat (20) @(negedge clk);
    mark_bit = 1'b0;
    drain();
    mp_mode = 1'b0;

    // R8 overrun: third write replaces the buffered byte
    push(8'hC3, 0, 1'b1);
    wr(8'hC3);
    wr(8'h11);
    @(negedge clk);
    chk("R8 no overrun on first refill", overrun, 0);
    push(8'h7E, 1, 1'b1);
    wr(8'h7E);
    @(negedge clk);
    chk("R8 overrun set", overrun, 1);
    drain();
    chk("R8 overrun sticky", overrun, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule